// File: doc/BRIEF.md
# Narrow Transfer Byte Lane Strobe Generator

This block works out which byte lanes of a wide data bus carry a beat of a burst whose transfer size may be narrower than the bus. Each request carries one beat's address, the transfer size code, and a flag that marks the opening beat of the burst. For every request the block returns the lowest active lane, the highest active lane, and a write strobe with one bit per bus byte. The address sequence itself comes from an external burst address generator, and the block does not move or steer any data.

The opening beat may sit at an unaligned address. Its lanes run from the byte the address points at up to the end of the naturally aligned container of the transfer size. Later beats are treated as aligned. Narrow beats walk across the lanes of the wider bus as the address advances. A size code that asks for more bytes than the bus holds raises an error flag and gives an empty strobe.

Requests enter and results leave through valid/ready handshakes, with one register stage between them. A request is taken on a rising clock edge when `req_valid` and `req_ready` are both high. Its result is presented on the next cycle and is held unchanged until the consumer raises `rsp_ready`. A new request can be taken in the same cycle in which the held result is consumed.

Top module: `strb_lane_gen`

## Requirements
- R1: During and right after reset, `rsp_valid` is low and `req_ready` is high.
- R2: A request taken on a clock edge (`req_valid` and `req_ready` both high) appears with `rsp_valid` high after that edge. `req_ready` is high whenever `rsp_valid` is low or `rsp_ready` is high.
- R3: While `rsp_valid` is high and `rsp_ready` is low, the result stays valid and all result fields keep their values.
- R4: The size code `req_size` gives 2^`req_size` bytes per beat (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 on the default 8-byte bus).
- R5: On an opening beat (`req_first` = 1), the low lane equals the address modulo the bus width in bytes. For example, address 0x1 with size 0 gives lane 1.
- R6: On an opening beat, the high lane equals (the address rounded down to a multiple of the beat size) modulo the bus width, plus the beat size minus 1. For example, size 2 at address 0x7 on an 8-byte bus gives lanes 7..7 and strobe 0x80.
- R7: On a later beat (`req_first` = 0), the address bits below the beat size are ignored. The low lane is the aligned address modulo the bus width, and the high lane is the low lane plus the beat size minus 1. For example, size 2 at 0x4 or at 0x6 gives lanes 4..7.
- R8: Strobe bit i is set exactly when the low lane ≤ i ≤ the high lane.
- R9: A size code whose beat size exceeds the bus width sets `rsp_err`, and its strobe, low lane and high lane are all zero. Legal sizes give `rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_first | input | 1 | Beat is the opening beat of its burst |
| req_addr | input | ADDR_W | Beat address |
| req_size | input | 3 | Transfer size code, bytes = 2^code |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_lo | output | $clog2(BUS_BYTES) | Lowest active byte lane |
| rsp_hi | output | $clog2(BUS_BYTES) | Highest active byte lane |
| rsp_strb | output | BUS_BYTES | Byte lane strobe |
| rsp_err | output | 1 | Size code wider than the bus |

## Verification
The two things that can happen in the same cycle are the hand-off of a held result to the consumer and the capture of the next request into the same register. The bench provokes this by keeping requests back to back while it toggles `rsp_ready` in a repeating pattern. Some edges therefore stall, some consume only, and some consume and refill at once. A scoreboard queue judges the result: it must see every expected strobe exactly once and in order, and the fields of any stalled result must not change across the stall.

// File: rtl/strb_gen_pkg.sv
package strb_gen_pkg;
  // Width of the transfer size code.
  localparam int SIZE_W = 3;

  // Number of lane index bits for a bus of the given width in bytes.
  function automatic int lane_bits(input int bus_bytes);
    return (bus_bytes < 2) ? 1 : $clog2(bus_bytes);
  endfunction
endpackage

// File: rtl/strb_lane_calc.sv
module strb_lane_calc
  import strb_gen_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input  logic                                first,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [SIZE_W-1:0]                   size,
  output logic [lane_bits(BUS_BYTES)-1:0]     lo,
  output logic [lane_bits(BUS_BYTES)-1:0]     hi,
  output logic                                err
);
  localparam int LANE_W = lane_bits(BUS_BYTES);
  localparam int MAX_SZ = $clog2(BUS_BYTES);

  logic [ADDR_W-1:0] align_mask;
  logic [ADDR_W-1:0] aligned;
  logic [LANE_W:0]   span;

  always_comb begin
    err        = (int'(size) > MAX_SZ);
    align_mask = {ADDR_W{1'b1}} << size;
    aligned    = addr & align_mask;
    span       = ((LANE_W+1)'(1) << size) - (LANE_W+1)'(1);
    if (err) begin
      lo = '0;
      hi = '0;
    end else begin
      lo = first ? addr[LANE_W-1:0] : aligned[LANE_W-1:0];
      hi = aligned[LANE_W-1:0] + span[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/strb_range_mask.sv
module strb_range_mask
  import strb_gen_pkg::*;
#(
  parameter int BUS_BYTES = 8
) (
  input  logic                            en,
  input  logic [lane_bits(BUS_BYTES)-1:0] lo,
  input  logic [lane_bits(BUS_BYTES)-1:0] hi,
  output logic [BUS_BYTES-1:0]            strb
);
  localparam int LANE_W = lane_bits(BUS_BYTES);

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign strb[i] = en && (LANE_W'(i) >= lo) && (LANE_W'(i) <= hi);
  end
endmodule

// File: rtl/strb_out_stage.sv
module strb_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/strb_lane_gen.sv
module strb_lane_gen
  import strb_gen_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_first,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [SIZE_W-1:0]               req_size,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [lane_bits(BUS_BYTES)-1:0] rsp_lo,
  output logic [lane_bits(BUS_BYTES)-1:0] rsp_hi,
  output logic [BUS_BYTES-1:0]            rsp_strb,
  output logic                            rsp_err
);
  localparam int LANE_W = lane_bits(BUS_BYTES);
  localparam int PKT_W  = 1 + 2*LANE_W + BUS_BYTES;

  logic [LANE_W-1:0]    c_lo, c_hi;
  logic                 c_err;
  logic [BUS_BYTES-1:0] c_strb;
  logic [PKT_W-1:0]     pkt_in, pkt_out;

  strb_lane_calc #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_calc (
    .first (req_first),
    .addr  (req_addr),
    .size  (req_size),
    .lo    (c_lo),
    .hi    (c_hi),
    .err   (c_err)
  );

  strb_range_mask #(.BUS_BYTES(BUS_BYTES)) u_mask (
    .en   (!c_err),
    .lo   (c_lo),
    .hi   (c_hi),
    .strb (c_strb)
  );

  assign pkt_in = {c_err, c_hi, c_lo, c_strb};

  strb_out_stage #(.W(PKT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pkt_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pkt_out)
  );

  assign {rsp_err, rsp_hi, rsp_lo, rsp_strb} = pkt_out;
endmodule

// File: rtl/strb_gen_chk.sv
module strb_gen_chk
  import strb_gen_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic                            req_ready,
  input logic                            rsp_valid,
  input logic                            rsp_ready,
  input logic [lane_bits(BUS_BYTES)-1:0] rsp_lo,
  input logic [lane_bits(BUS_BYTES)-1:0] rsp_hi,
  input logic [BUS_BYTES-1:0]            rsp_strb,
  input logic                            rsp_err
);
  // R2
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  // R2
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_strb) &&
      $stable(rsp_lo) && $stable(rsp_hi) && $stable(rsp_err)));

  // R9
  err_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_strb == '0));

  // R8
  strb_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |->
      ($countones(rsp_strb) == int'(rsp_hi) - int'(rsp_lo) + 1));

  // R8
  strb_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_strb[rsp_lo] && rsp_strb[rsp_hi]));
endmodule

bind strb_lane_gen strb_gen_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_lo    (rsp_lo),
  .rsp_hi    (rsp_hi),
  .rsp_strb  (rsp_strb),
  .rsp_err   (rsp_err)
);

// File: tb/sim_strb_lane_gen.sv
module sim_strb_lane_gen;
  localparam int ADDR_W    = 32;
  localparam int BUS_BYTES = 8;
  localparam int LANE_W    = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_first = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0]        req_size = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [LANE_W-1:0] rsp_lo, rsp_hi;
  logic [BUS_BYTES-1:0] rsp_strb;
  logic              rsp_err;

  int checks = 0;
  int fails  = 0;
  int sent   = 0;
  int got    = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [LANE_W-1:0]    lo;
    logic [LANE_W-1:0]    hi;
    logic [BUS_BYTES-1:0] strb;
    logic                 err;
    string                tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  strb_lane_gen #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u0 (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Reference model: R4 size coding, R5/R6 opening beat, R7 later beat,
  // R8 strobe range, R9 oversize error.
  function automatic exp_t model(input bit first, input int addr, input int size,
                                 input string tag);
    exp_t e;
    int n, base, lo, hi;
    n = 1 << size;
    e.tag = tag;
    if (n > BUS_BYTES) begin
      e.err = 1'b1; e.lo = '0; e.hi = '0; e.strb = '0;
      return e;
    end
    base = (addr / n) * n;
    lo   = first ? (addr % BUS_BYTES) : (base % BUS_BYTES);
    hi   = (base % BUS_BYTES) + n - 1;
    e.err = 1'b0;
    e.lo  = LANE_W'(lo);
    e.hi  = LANE_W'(hi);
    e.strb = '0;
    for (int i = 0; i < BUS_BYTES; i++)
      if (i >= lo && i <= hi) e.strb[i] = 1'b1;
    return e;
  endfunction

  task automatic send(input bit first, input int addr, input int size,
                      input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_first = first;
    req_addr  = ADDR_W'(addr);
    req_size  = 3'(size);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(model(first, addr, size, tag));
    sent++;
    @(posedge clk);
    #0.1;
    req_valid = 1'b0;
  endtask

  // Monitor: compares each consumed result with the scoreboard head, and
  // watches held results across stalls (R3).
  initial begin : monitor
    bit held = 1'b0;
    logic [BUS_BYTES-1:0] h_strb;
    logic [LANE_W-1:0] h_lo, h_hi;
    logic h_err;
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (held && rst_n) begin
        check(rsp_valid && rsp_strb == h_strb && rsp_lo == h_lo &&
              rsp_hi == h_hi && rsp_err == h_err, "R3", "stalled result",
              {rsp_valid, rsp_strb}, {1'b1, h_strb});
      end
      held = 1'b0;
      if (rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected result", rsp_strb, 0);
        end else begin
          e = sb.pop_front();
          got++;
          check(rsp_strb == e.strb, e.tag, "strobe", rsp_strb, e.strb);
          check(rsp_lo == e.lo && rsp_hi == e.hi, e.tag, "lanes lo,hi",
                {rsp_lo, rsp_hi}, {e.lo, e.hi});
          check(rsp_err == e.err, e.tag, "err", rsp_err, e.err);
        end
      end else if (rsp_valid && !rsp_ready) begin
        held = 1'b1;
        h_strb = rsp_strb; h_lo = rsp_lo; h_hi = rsp_hi; h_err = rsp_err;
      end
    end
  end

  // Consumer pattern: ready on 2 of every 3 cycles once enabled.
  bit rdy_pattern = 1'b0;
  initial begin : consumer
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      rsp_ready = rdy_pattern ? (k % 3 != 0) : 1'b1;
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R2", "watchdog expired", got, sent);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(!rsp_valid, "R1", "rsp_valid in reset", rsp_valid, 0);
    check(req_ready,  "R1", "req_ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!rsp_valid && req_ready, "R1", "idle after reset",
          {rsp_valid, req_ready}, 2'b01);

    // Directed corner cases
    send(1, 'h7, 2, "R6");   // top lane only, 0x80
    send(1, 'h1, 0, "R5");   // lane 1
    send(1, 'h4, 2, "R8");   // lanes 4..7
    send(0, 'h6, 2, "R7");   // low bits ignored -> lanes 4..7
    send(0, 'h3, 1, "R7");   // lanes 2..3
    send(1, 'h5, 3, "R6");   // full-width container, lanes 5..7
    send(1, 'h0, 4, "R9");   // 16 bytes on 8-byte bus
    send(0, 'h9, 7, "R9");
    send(1, 'hF, 0, "R4");   // single byte lane 7

    // Sweep with back-pressure: consume and refill share cycles (R2, R3)
    rdy_pattern = 1'b1;
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 8; s++)
        for (int a = 0; a < 16; a++)
          send(f[0], 'h100 + a, s, f ? "R5" : "R7");
    // Narrow beats walking across lanes of a burst
    for (int b = 0; b < 8; b++)
      send(b == 0, 'h22 + 2*b, 1, "R7");

    rdy_pattern = 1'b0;
    repeat (6) @(negedge clk);
    check(sb.size() == 0 && got == sent, "R2", "all results delivered",
          got, sent);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule